// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers a configurable number of level-sensitive interrupt sources, grouped into banks of 32, and presents them to a processor as one request line. Each source passes through a synchroniser, is gated by a per-source mask bit and then counts as pending. Software changes mask bits only through two strobe registers per bank: one that sets mask bits and one that clears them. Bits written as zero leave the mask alone.

The request line is not a combinational OR of the pending bits. When the controller is open and at least one source is pending, it raises the request and captures the index of the lowest-numbered pending source. The request and the captured index then stay fixed, whatever the sources or masks do, until software writes the agreement bit in the control register. The write drops the request for one cycle. On the cycle after that the controller samples the pending sources again. All registers sit in a 4 KB window on a simple 32-bit register bus, with read data registered one cycle after the read strobe.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After synchronous reset every mask bit of every bank reads 1, `irq_o` is low and the sorted-source register at 0x104 reads 0.
- R2: A write to bank offset 0x0C sets each mask bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R3: A write to bank offset 0x08 clears each mask bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R4: Bank g is reached at byte address g*0x20 plus the register offset. Source index g*32+b maps to bit b of bank g. Offset 0x04 reads the bank's mask.
- R5: Offset 0x00 reads the synchronised level of the bank's 32 sources, which follow the inputs within three clock cycles.
- R6: Offset 0x10 reads the synchronised sources ANDed with the inverted mask, so a masked source never reads as pending.
- R7: When the controller is open and any source is pending, `irq_o` rises on the next clock edge and the sorted-source register (0x104, bits 6:0) holds the index of the lowest-numbered pending source.
- R8: While `irq_o` is high and no agreement write occurs, `irq_o` and the sorted-source index stay unchanged, even when sources or masks change.
- R9: A write to 0x100 with bit 0 set is the agreement write. It drives `irq_o` low on that clock edge, and the controller samples again on the next edge. A write to 0x100 with bit 0 clear has no effect.
- R10: Reads of the two mask strobe offsets (0x08, 0x0C), of the control register and of unmapped addresses return zero.
- R11: Sources are level sensitive. Once a source has dropped and an agreement write has occurred, that source raises no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 96 | Level interrupt sources, asynchronous to clk |
| bus_addr | input | 12 | Byte address inside the 4 KB register window |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions take two things as given. Bus accesses are word aligned. The agreement write can be recognised from the full word address together with bit 0 of the write data. They take nothing as given about the timing of the sources: those inputs may change on any cycle, and the hold property must survive that. The stimulus keeps to aligned addresses and to one strobe per access. It changes sources and masks freely while a request is held, so that the hold and the lowest-index capture are exercised against changing pending sets.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam logic [4:0] OFS_RAW  = 5'h00;
  localparam logic [4:0] OFS_MASK = 5'h04;
  localparam logic [4:0] OFS_MCLR = 5'h08;
  localparam logic [4:0] OFS_MSET = 5'h0C;
  localparam logic [4:0] OFS_PEND = 5'h10;
  localparam int unsigned CTRL_BYTE = 32'h100;
  localparam int unsigned SORT_BYTE = 32'h104;
  localparam int unsigned BANK_STRIDE_LOG2 = 5;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 96,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] raw_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] pend_o
);
  logic [BANK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '1;
    else if (set_we) mask_q <= mask_q | wdata;
    else if (clr_we) mask_q <= mask_q & ~wdata;
  end

  assign mask_o = mask_q;
  assign pend_o = raw_i & ~mask_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 96,
  parameter int NUM_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               agree_i,
  output logic               irq_o,
  output logic [NUM_W-1:0]   num_o
);
  logic             held_q;
  logic [NUM_W-1:0] num_q;
  logic             any_pend;
  logic [NUM_W-1:0] lowest;

  always_comb begin
    any_pend = |pend_i;
    lowest   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) lowest = NUM_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      num_q  <= '0;
    end else if (agree_i) begin
      held_q <= 1'b0;
    end else if (!held_q && any_pend) begin
      held_q <= 1'b1;
      num_q  <= lowest;
    end
  end

  assign irq_o = held_q;
  assign num_o = num_q;
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*BANK_W-1:0]   irq_src_i,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [BANK_W-1:0]             bus_wdata,
  input  logic                          bus_rd,
  output logic [BANK_W-1:0]             bus_rdata,
  output logic                          irq_o
);
  import irq_ctrl_pkg::*;

  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int NUM_W   = $clog2(NUM_SRC);
  localparam int SEL_W   = ADDR_W - BANK_STRIDE_LOG2;
  localparam logic [ADDR_W-3:0] CTRL_WORD = (ADDR_W-2)'(CTRL_BYTE >> 2);
  localparam logic [ADDR_W-3:0] SORT_WORD = (ADDR_W-2)'(SORT_BYTE >> 2);

  logic [NUM_SRC-1:0] raw_flat;
  logic [NUM_SRC-1:0] pend_flat;
  logic [BANK_W-1:0]  raw_bank  [NUM_BANKS];
  logic [BANK_W-1:0]  mask_bank [NUM_BANKS];
  logic [BANK_W-1:0]  pend_bank [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;

  logic [SEL_W-1:0]  bank_sel;
  logic [4:0]        ofs;
  logic [ADDR_W-3:0] word_addr;
  logic              agree;
  logic [NUM_W-1:0]  sort_num;
  logic [BANK_W-1:0] rd_mux;
  logic [BANK_W-1:0] rdata_q;

  assign bank_sel  = bus_addr[ADDR_W-1:BANK_STRIDE_LOG2];
  assign ofs       = {bus_addr[4:2], 2'b00};
  assign word_addr = bus_addr[ADDR_W-1:2];
  assign agree     = bus_wr && (word_addr == CTRL_WORD) && bus_wdata[0];

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (irq_src_i),
    .q_o (raw_flat)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic set_we;
    logic clr_we;
    assign bank_hit[g]  = (bank_sel == SEL_W'(g));
    assign raw_bank[g]  = raw_flat[g*BANK_W +: BANK_W];
    assign set_we       = bus_wr && bank_hit[g] && (ofs == OFS_MSET);
    assign clr_we       = bus_wr && bank_hit[g] && (ofs == OFS_MCLR);

    irq_mask_bank #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (bus_wdata),
      .raw_i  (raw_bank[g]),
      .mask_o (mask_bank[g]),
      .pend_o (pend_bank[g])
    );

    assign pend_flat[g*BANK_W +: BANK_W] = pend_bank[g];
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .pend_i  (pend_flat),
    .agree_i (agree),
    .irq_o   (irq_o),
    .num_o   (sort_num)
  );

  always_comb begin
    rd_mux = '0;
    if (word_addr == SORT_WORD) begin
      rd_mux = BANK_W'(sort_num);
    end else begin
      for (int g = 0; g < NUM_BANKS; g++) begin
        if (bank_hit[g]) begin
          case (ofs)
            OFS_RAW:  rd_mux = raw_bank[g];
            OFS_MASK: rd_mux = mask_bank[g];
            OFS_PEND: rd_mux = pend_bank[g];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_SRC = 96,
  parameter int NUM_W   = 7,
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BANK_W-1:0]  bus_wdata,
  input logic [BANK_W-1:0]  bus_rdata,
  input logic               irq_o,
  input logic [NUM_W-1:0]   irq_num,
  input logic [NUM_SRC-1:0] pend_vec
);
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  logic agree_seen;
  logic strobe_rd;
  assign agree_seen = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(10'h040)) && bus_wdata[0];
  assign strobe_rd  = bus_rd && ((bus_addr[4:2] == 3'd2) || (bus_addr[4:2] == 3'd3));

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && irq_num == '0));

  a_r7_lowest_pending: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ((((($past(pend_vec)) >> irq_num) & ONE) != '0) &&
                      (($past(pend_vec) & ((ONE << irq_num) - ONE)) == '0)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !agree_seen) |=> (irq_o && $stable(irq_num)));

  a_r9_agree_drops: assert property (@(posedge clk) disable iff (rst)
    agree_seen |=> !irq_o);

  a_r10_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
    strobe_rd |=> (bus_rdata == '0));
endmodule

bind banked_irq_ctrl irq_ctrl_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_W   (NUM_W),
  .ADDR_W  (ADDR_W),
  .BANK_W  (BANK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .irq_num   (sort_num),
  .pend_vec  (pend_flat)
);

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
  localparam int NB = 3;
  localparam int BW = 32;
  localparam int NS = NB * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic [11:0]   addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic          rd = 1'b0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  banked_irq_ctrl dut (
    .clk (clk), .rst (rst), .irq_src_i (src), .bus_addr (addr),
    .bus_wr (wr), .bus_wdata (wdata), .bus_rd (rd), .bus_rdata (rdata), .irq_o (irq)
  );

  localparam int NV = 4;
  localparam logic [NS-1:0] V_SRC [NV] = '{
    (96'h1 << 5) | (96'h1 << 70),
    (96'h1 << 33) | (96'h1 << 40) | (96'h1 << 64),
    (96'h1 << 95) | (96'h1 << 64),
    (96'h1 << 31) | (96'h1 << 32)
  };
  localparam int          V_BANK [NV] = '{0, 1, 2, 0};
  localparam logic [31:0] V_UNM  [NV] = '{32'hFFFF_FFFF, 32'h0000_0100, 32'h8000_0000, 32'h7FFF_FFFF};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic mask_all();
    for (int b = 0; b < NB; b++) bus_write(12'(b * 32 + 12), 32'hFFFF_FFFF);
  endtask

  function automatic int lowest_of(input logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NS-1:0] pend;
    int lo;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state, R4 bank mask addressing
    check("R1 irq", 32'(irq), 32'd0);
    bus_read(12'h104, d); check("R1 sorted", d, 32'd0);
    for (int b = 0; b < NB; b++) begin
      bus_read(12'(b * 32 + 4), d); check("R1 R4 mask reset", d, 32'hFFFF_FFFF);
    end

    // vector table: R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      mask_all();
      bus_write(12'h100, 32'h1);
      src = V_SRC[v];
      tick(4);
      bus_write(12'(V_BANK[v] * 32 + 8), V_UNM[v]);
      bus_write(12'h100, 32'h1);
      tick(1);
      pend = '0;
      pend[V_BANK[v]*BW +: BW] = V_SRC[v][V_BANK[v]*BW +: BW] & V_UNM[v];
      lo = lowest_of(pend);
      check("R7 irq vector", 32'(irq), (lo >= 0) ? 32'd1 : 32'd0);
      if (lo >= 0) begin
        bus_read(12'h104, d); check("R7 R4 sorted vector", d, 32'(lo));
      end
      bus_read(12'(V_BANK[v] * 32 + 16), d);
      check("R6 pending vector", d, pend[V_BANK[v]*BW +: BW]);
    end

    // R5 raw status
    mask_all();
    src = '0;
    bus_write(12'h100, 32'h1);
    tick(4);
    src = (96'h1 << 3) | (96'h1 << 37);
    tick(3);
    bus_read(12'h000, d); check("R5 raw bank0", d, 32'h0000_0008);
    bus_read(12'h020, d); check("R5 raw bank1", d, 32'h0000_0020);
    bus_read(12'h010, d); check("R6 masked not pending", d, 32'h0);
    check("R6 masked no irq", 32'(irq), 32'd0);

    // R2 R3 partial mask updates
    bus_write(12'h008, 32'h0000_00F0);
    bus_read(12'h004, d); check("R3 clear", d, 32'hFFFF_FF0F);
    bus_write(12'h00C, 32'h0000_0010);
    bus_read(12'h004, d); check("R2 set", d, 32'hFFFF_FF1F);
    bus_write(12'h008, 32'h0000_0008);
    bus_read(12'h004, d); check("R3 clear bit3", d, 32'hFFFF_FF17);
    bus_read(12'h010, d); check("R6 pending bit3", d, 32'h0000_0008);
    check("R7 irq on", 32'(irq), 32'd1);
    bus_read(12'h104, d); check("R7 sorted 3", d, 32'd3);

    // R8 hold while a lower source appears
    bus_write(12'h008, 32'h0000_0002);
    src[1] = 1'b1;
    tick(4);
    check("R8 irq held", 32'(irq), 32'd1);
    bus_read(12'h104, d); check("R8 sorted held", d, 32'd3);
    bus_write(12'h100, 32'h0);
    check("R9 zero write no effect irq", 32'(irq), 32'd1);
    bus_read(12'h104, d); check("R9 zero write no effect sorted", d, 32'd3);

    // R9 agreement
    bus_write(12'h100, 32'h1);
    check("R9 irq drops", 32'(irq), 32'd0);
    tick(1);
    check("R9 irq re-raised", 32'(irq), 32'd1);
    bus_read(12'h104, d); check("R9 new sorted", d, 32'd1);

    // R11 level sources gone
    src = '0;
    tick(4);
    bus_write(12'h100, 32'h1);
    tick(3);
    check("R11 no request", 32'(irq), 32'd0);

    // R10 zero reads
    bus_read(12'h008, d); check("R10 clear strobe", d, 32'h0);
    bus_read(12'h02C, d); check("R10 set strobe", d, 32'h0);
    bus_read(12'h100, d); check("R10 control", d, 32'h0);
    bus_read(12'h300, d); check("R10 unmapped", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule